// File: doc/BRIEF.md
# Virtual Interrupt Flag Controller

This block is the flag-update unit of a small CPU model that runs legacy virtual-8086 code. Each decoded CLI or STI has one of three outcomes. It can update the real interrupt-enable flag (IF). It can update a virtual shadow of that flag (VIF). Or it can raise a one-cycle general-protection fault pulse. The outcome depends on the virtual-mode indicator, the extension-enable control, the I/O privilege level and the current privilege level.

The block also produces the interrupt-take pulse that is sampled at instruction boundaries. Interrupt recognition depends on IF alone. When the extension is on, CLI and STI in virtual mode touch only VIF, so a guest's wish not to be interrupted is recorded without blocking real interrupts and without a trap. The virtual-interrupt-pending flag (VIP) is owned by software through a dedicated write port. A fixed capability word reports that the extension is supported.

Top module: `vif_ctl`

## Requirements
- R1: After reset, if_flag, vif_flag, vip_flag, gp_fault and int_take are all 0.
- R2: With ext_en=1 and vmode=1, a decoded CLI (dec_op=0) clears vif_flag, leaves if_flag unchanged and raises no fault.
- R3: With ext_en=1 and vmode=1, a decoded STI (dec_op=1) sets vif_flag, leaves if_flag unchanged and raises no fault.
- R4: With ext_en=0 and vmode=1, CLI/STI write dec_op into if_flag when iopl=3. Otherwise they pulse gp_fault for one cycle and leave if_flag and vif_flag unchanged.
- R5: With vmode=0, CLI/STI write dec_op into if_flag when cpl<=iopl. Otherwise they pulse gp_fault for one cycle and leave the flags unchanged. ext_en has no effect here.
- R6: int_take pulses high for exactly the cycle after an edge at which boundary=1, intr_req=1 and if_flag=1. It stays 0 when if_flag=0, whatever the value of vif_flag.
- R7: When an interrupt is taken on a cycle, a decode on that same cycle is dropped: no flag changes and no fault.
- R8: vip_flag changes only through vip_we/vip_wd. CLI and STI never alter it.
- R9: cap_word has bit 1 set to report the extension, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Virtual-mode extension enable |
| vmode | input | 1 | Core is in virtual-8086 mode |
| iopl | input | PL_W | I/O privilege level |
| cpl | input | PL_W | Current privilege level |
| dec_valid | input | 1 | CLI/STI decode strobe |
| dec_op | input | 1 | 0 = CLI, 1 = STI |
| boundary | input | 1 | Instruction boundary strobe |
| intr_req | input | 1 | External interrupt request |
| vip_we | input | 1 | Software write enable for VIP |
| vip_wd | input | 1 | Software write data for VIP |
| if_flag | output | 1 | Real interrupt-enable flag |
| vif_flag | output | 1 | Virtual interrupt flag |
| vip_flag | output | 1 | Virtual interrupt pending flag |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |
| int_take | output | 1 | One-cycle interrupt-take pulse |
| cap_word | output | CAP_W | Capability word, bit 1 = extension present |

## Verification
Every result is registered once. Flag updates, the fault pulse and the take pulse all appear one clock edge after the inputs that cause them are sampled, and the pulses drop at the edge after that unless they are retriggered. The bench drives inputs on the falling edge. It samples the outputs on the next falling edge, which is one rising edge later, and it checks that the pulses are back to 0 on the falling edge after that. cap_word is constant and can be checked at any time.

// File: rtl/vif_ctl.sv
module vif_ctl #(
  parameter int PL_W  = 2,
  parameter int CAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic             vmode,
  input  logic [PL_W-1:0]  iopl,
  input  logic [PL_W-1:0]  cpl,
  input  logic             dec_valid,
  input  logic             dec_op,
  input  logic             boundary,
  input  logic             intr_req,
  input  logic             vip_we,
  input  logic             vip_wd,
  output logic             if_flag,
  output logic             vif_flag,
  output logic             vip_flag,
  output logic             gp_fault,
  output logic             int_take,
  output logic [CAP_W-1:0] cap_word
);
  localparam logic [PL_W-1:0] PL_MAX = '1;

  logic take_now, dec_go, virt, priv_ok, fault_now;

  assign take_now  = boundary & intr_req & if_flag;
  assign dec_go    = dec_valid & ~take_now;
  assign virt      = vmode & ext_en;
  assign priv_ok   = vmode ? (iopl == PL_MAX) : (cpl <= iopl);
  assign fault_now = dec_go & ~virt & ~priv_ok;

  assign cap_word  = {{(CAP_W-2){1'b0}}, 1'b1, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_flag  <= 1'b0;
      vif_flag <= 1'b0;
      vip_flag <= 1'b0;
      gp_fault <= 1'b0;
      int_take <= 1'b0;
    end else begin
      int_take <= take_now;
      gp_fault <= fault_now;
      if (dec_go && virt)             vif_flag <= dec_op;
      if (dec_go && !virt && priv_ok) if_flag  <= dec_op;
      if (vip_we)                     vip_flag <= vip_wd;
    end
  end
endmodule

module vif_ctl_chk #(
  parameter int PL_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_en,
  input logic            vmode,
  input logic            dec_valid,
  input logic            boundary,
  input logic            intr_req,
  input logic            vip_we,
  input logic            if_flag,
  input logic            vif_flag,
  input logic            vip_flag,
  input logic            gp_fault,
  input logic            int_take
);
  a_r6_take_needs_if: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> $past(boundary && intr_req && if_flag));

  a_r8_vip_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vip_we) |-> vip_flag == $past(vip_flag));

  a_r4_fault_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (if_flag == $past(if_flag)) && (vif_flag == $past(vif_flag)));

  a_r2_virt_keeps_if: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_valid && vmode && ext_en) |-> if_flag == $past(if_flag));

  a_r7_take_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> !gp_fault);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !if_flag && !vif_flag && !vip_flag && !gp_fault && !int_take);
endmodule

bind vif_ctl vif_ctl_chk #(.PL_W(PL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .vmode(vmode),
  .dec_valid(dec_valid), .boundary(boundary), .intr_req(intr_req),
  .vip_we(vip_we), .if_flag(if_flag), .vif_flag(vif_flag),
  .vip_flag(vip_flag), .gp_fault(gp_fault), .int_take(int_take)
);

// File: tb/tb_vif_ctl.sv
module tb_vif_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0, vmode = 1'b0;
  logic [1:0] iopl = 2'd0, cpl = 2'd0;
  logic dec_valid = 1'b0, dec_op = 1'b0, boundary = 1'b0, intr_req = 1'b0;
  logic vip_we = 1'b0, vip_wd = 1'b0;
  logic if_flag, vif_flag, vip_flag, gp_fault, int_take;
  logic [31:0] cap_word;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vif_ctl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a decode and return sampled outputs one edge later
  task automatic op(input logic vm, input logic ext, input logic [1:0] io,
                    input logic [1:0] cp, input logic o);
    vmode = vm; ext_en = ext; iopl = io; cpl = cp; dec_op = o; dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic set_if(input logic v);
    op(1'b0, 1'b0, 2'd0, 2'd0, v);
  endtask

  task automatic set_vif(input logic v);
    op(1'b1, 1'b1, 2'd0, 2'd3, v);
  endtask

  task automatic t_reset;
    chk("R1 if", if_flag, 0); chk("R1 vif", vif_flag, 0); chk("R1 vip", vip_flag, 0);
    chk("R1 fault", gp_fault, 0); chk("R1 take", int_take, 0);
  endtask

  task automatic t_virtual;
    set_if(1'b1);
    set_vif(1'b1);
    op(1'b1, 1'b1, 2'd0, 2'd3, 1'b0);
    chk("R2 vif cleared", vif_flag, 0); chk("R2 if kept", if_flag, 1);
    chk("R2 no fault", gp_fault, 0);
    set_if(1'b0);
    op(1'b1, 1'b1, 2'd1, 2'd3, 1'b1);
    chk("R3 vif set", vif_flag, 1); chk("R3 if kept", if_flag, 0);
    chk("R3 no fault", gp_fault, 0); chk("R8 vip kept", vip_flag, 0);
  endtask

  task automatic t_legacy_vm;
    set_if(1'b0); set_vif(1'b1);
    op(1'b1, 1'b0, 2'd3, 2'd3, 1'b1);
    chk("R4 iopl3 sti if", if_flag, 1); chk("R4 iopl3 no fault", gp_fault, 0);
    chk("R4 vif kept", vif_flag, 1);
    op(1'b1, 1'b0, 2'd2, 2'd3, 1'b0);
    chk("R4 fault pulse", gp_fault, 1); chk("R4 if kept", if_flag, 1);
    chk("R4 vif kept on fault", vif_flag, 1);
    @(negedge clk);
    chk("R4 fault one cycle", gp_fault, 0);
  endtask

  task automatic t_protected;
    set_if(1'b1);
    op(1'b0, 1'b1, 2'd1, 2'd1, 1'b0);
    chk("R5 cpl=iopl cli", if_flag, 0); chk("R5 no fault", gp_fault, 0);
    op(1'b0, 1'b0, 2'd1, 2'd2, 1'b1);
    chk("R5 cpl>iopl fault", gp_fault, 1); chk("R5 if kept", if_flag, 0);
    op(1'b0, 1'b1, 2'd0, 2'd0, 1'b1);
    chk("R5 ext ignored sti", if_flag, 1);
  endtask

  task automatic t_intr;
    set_if(1'b0); set_vif(1'b1);
    boundary = 1'b1; intr_req = 1'b1;
    @(negedge clk);
    chk("R6 blocked if=0 vif=1", int_take, 0);
    boundary = 1'b0; intr_req = 1'b0;
    set_if(1'b1); set_vif(1'b0);
    intr_req = 1'b1;
    @(negedge clk);
    chk("R6 no take without boundary", int_take, 0);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk("R6 take if=1 vif=0", int_take, 1);
    @(negedge clk);
    intr_req = 1'b0;
    chk("R6 take one cycle", int_take, 0);
  endtask

  task automatic t_priority;
    set_if(1'b1); set_vif(1'b1);
    boundary = 1'b1; intr_req = 1'b1;
    op(1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
    boundary = 1'b0; intr_req = 1'b0;
    chk("R7 take", int_take, 1); chk("R7 if kept", if_flag, 1);
    chk("R7 no fault", gp_fault, 0);
    boundary = 1'b1; intr_req = 1'b1;
    op(1'b1, 1'b1, 2'd0, 2'd3, 1'b0);
    boundary = 1'b0; intr_req = 1'b0;
    chk("R7 vif kept", vif_flag, 1);
    boundary = 1'b1; intr_req = 1'b1;
    op(1'b0, 1'b0, 2'd0, 2'd3, 1'b0);
    boundary = 1'b0; intr_req = 1'b0;
    chk("R7 fault dropped", gp_fault, 0);
  endtask

  task automatic t_vip;
    vip_we = 1'b1; vip_wd = 1'b1;
    @(negedge clk);
    vip_we = 1'b0;
    chk("R8 vip written", vip_flag, 1);
    set_vif(1'b0); set_if(1'b0); op(1'b1, 1'b0, 2'd0, 2'd3, 1'b1);
    chk("R8 vip kept after ops", vip_flag, 1);
    vip_wd = 1'b0; @(negedge clk);
    chk("R8 vip needs we", vip_flag, 1);
    vip_we = 1'b1; @(negedge clk); vip_we = 1'b0;
    chk("R8 vip cleared", vip_flag, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    chk("R9 capability", cap_word, 32'h2);
    t_virtual;
    t_legacy_vm;
    t_protected;
    t_intr;
    t_priority;
    t_vip;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule